// File: doc/BRIEF.md
# Microsequenced Memory Operation Controller

This block sits between several bus requesters and a word-wide memory. While it is idle, it picks one pending request by fixed priority. It raises an address-latch strobe for one cycle and latches the winner's address, its write/read opcode and its byte-enable mask. A second, separate copy of the address is kept for error reporting. The decoded opcode selects one of three fixed entry points in an internal micro-instruction ROM. The sequencer then steps one micro-instruction per cycle, and each instruction issues the memory start, the write-data load, the read-data capture and the completion controls.

Three operations are supported: a read, a full-word write, and a partial write. The partial write runs as a hidden read of the addressed word. The requester's write data is loaded into an internal data register, and the read bytes are merged into that register only where the mask says the byte must be kept. The merged word is then written back. The memory is modelled as a block-RAM-style array that returns read data a fixed three cycles after the start pulse. A syndrome input comes from an external checker and is sampled when read data is captured. If the syndrome is non-zero, the operation is extended by one extra cycle before completion. The first such error latches the saved address and the syndrome until software clears it, and later errors only set a sticky overflow flag.

Completion is signalled to every requester by a one-cycle ready pulse. A read returns its data together with a data-valid pulse in that same cycle.

Top module: `mop_seq`

## Requirements
- R1: After synchronous reset, `ale`, `grant`, `ready`, `rd_valid`, `err_valid` and `err_ovf` are all 0.
- R2: Arbitration and busy behaviour:
  - While idle, a request on lane i (`req_valid[i]`) is granted when no lower-numbered lane is requesting; lane 0 has the highest priority.
  - In the cycle after the request is sampled, `ale` is high for exactly one cycle.
  - `grant` is one-hot with bit i set, and it stays set until the operation completes.
  - New requests are ignored while an operation is in progress: `ale` stays low.
- R3: A read (`req_wr[i]`=0, mask ignored) makes `ready` and `rd_valid` rise 5 cycles after the `ale` cycle. `rd_data` then carries the stored word at the latched address (`req_addr[i*AW +: AW]`).
- R4: A full write (`req_wr[i]`=1 with every mask bit 1) completes with `ready` 2 cycles after the `ale` cycle, without `rd_valid`. The `wdata` value present during the `ale` cycle (the data phase) replaces the whole word. The syndrome input has no effect on a full write.
- R5: A partial write (`req_wr[i]`=1 with any other mask) completes with `ready` 5 cycles after the `ale` cycle, without `rd_valid`. For mask bit b (lane field `req_mask[i*NB +: NB]`), byte b (bits 8b+7..8b) of the word takes `wdata` when the bit is 1 and keeps its stored value when it is 0.
- R6: A write whose mask is all zero runs as a partial write and leaves the stored word unchanged.
- R7: For a read or partial write, the syndrome is sampled 3 cycles after the `ale` cycle. If it is non-zero, `ready` is delayed by one cycle, to 6 cycles after `ale`.
- R8: An error while `err_valid` is 0 sets `err_valid` and latches that operation's address into `err_addr` and its syndrome into `err_syn`. These hold until `err_clear` is pulsed.
- R9: An error while `err_valid` is 1 sets `err_ovf`, and `err_addr`/`err_syn` keep the first error.
- R10: A one-cycle `err_clear` with no error in the same cycle returns `err_valid` and `err_ovf` to 0.
- R11: `ready` is a one-cycle pulse, and `rd_valid` is never high without `ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NREQ | Per-lane request |
| req_wr | input | NREQ | Per-lane opcode: 1 write, 0 read |
| req_addr | input | NREQ*AW | Per-lane word address, lane i at bits i*AW |
| req_mask | input | NREQ*NB | Per-lane byte overwrite mask, lane i at bits i*NB |
| wdata | input | DW | Shared write data, valid in the data phase |
| syndrome | input | SW | Error-check syndrome, non-zero means error |
| err_clear | input | 1 | Clears the error latch and overflow flag |
| grant | output | NREQ | One-hot winner, held during the operation |
| ale | output | 1 | Address latch strobe, one cycle |
| ready | output | 1 | Operation complete pulse |
| rd_valid | output | 1 | Read data valid, with ready |
| rd_data | output | DW | Returned read data |
| err_valid | output | 1 | Error latch holds an entry |
| err_ovf | output | 1 | Sticky flag for errors after the first |
| err_addr | output | AW | Address of the first error |
| err_syn | output | SW | Syndrome of the first error |

## Verification
The hardest situation to reach is a second error while the latch is still full, together with a syndrome that must be ignored. To get there, the stimulus table contains a faulty read, then a faulty partial write with no clear in between, and then a full write carrying a non-zero syndrome. The bench checks that the partial write only raises the overflow flag, and that the full write neither extends its latency nor changes the latch. Requests from lower-priority lanes are kept asserted through each operation to show that they are ignored while busy. Every write is checked by later reads against a byte-level reference model kept in the bench.

// File: rtl/mop_pkg.sv
`timescale 1ns/1ps
package mop_pkg;
  typedef enum logic [1:0] {
    OP_READ = 2'd0,
    OP_FULL = 2'd1,
    OP_PART = 2'd2
  } op_e;

  localparam int UPC_W = 5;

  // fixed entry points of the three sequences and the extension slot
  localparam logic [UPC_W-1:0] UPC_READ = 5'd0;
  localparam logic [UPC_W-1:0] UPC_FULL = 5'd8;
  localparam logic [UPC_W-1:0] UPC_PART = 5'd16;
  localparam logic [UPC_W-1:0] UPC_EXT  = 5'd31;

  typedef struct packed {
    logic mstart;  // pulse memory start
    logic mwe;     // start is a write
    logic ldw;     // load write data into data register
    logic capt;    // capture / merge read data, sample syndrome
    logic last;    // final instruction of the sequence
  } uinst_t;
endpackage

// File: rtl/mop_arb.sv
`timescale 1ns/1ps
module mop_arb #(
  parameter int NREQ = 3
) (
  input  logic [NREQ-1:0] req,
  output logic [NREQ-1:0] gnt,
  output logic            any
);
  // lowest index wins: scan downwards so the last hit is the lowest
  always_comb begin
    gnt = '0;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
      end
    end
  end

  assign any = |req;
endmodule

// File: rtl/mop_urom.sv
`timescale 1ns/1ps
module mop_urom
  import mop_pkg::*;
#(
  parameter int LAT = 3
) (
  input  logic [UPC_W-1:0] upc,
  output uinst_t           ui
);
  localparam logic [UPC_W-1:0] RD_CAP  = UPC_READ + UPC_W'(LAT);
  localparam logic [UPC_W-1:0] RD_END  = RD_CAP + 5'd1;
  localparam logic [UPC_W-1:0] FW_WR   = UPC_FULL + 5'd1;
  localparam logic [UPC_W-1:0] PW_CAP  = UPC_PART + UPC_W'(LAT);
  localparam logic [UPC_W-1:0] PW_WR   = PW_CAP + 5'd1;

  always_comb begin
    ui = '0;
    unique case (upc)
      UPC_READ: ui.mstart = 1'b1;
      RD_CAP:   ui.capt   = 1'b1;
      RD_END:   ui.last   = 1'b1;
      UPC_FULL: ui.ldw    = 1'b1;
      FW_WR:    begin ui.mstart = 1'b1; ui.mwe = 1'b1; ui.last = 1'b1; end
      UPC_PART: begin ui.ldw = 1'b1; ui.mstart = 1'b1; end
      PW_CAP:   ui.capt   = 1'b1;
      PW_WR:    begin ui.mstart = 1'b1; ui.mwe = 1'b1; ui.last = 1'b1; end
      UPC_EXT:  ui.last   = 1'b1;
      default:  ui = '0;
    endcase
  end
endmodule

// File: rtl/mop_mem.sv
`timescale 1ns/1ps
module mop_mem #(
  parameter int AW  = 4,
  parameter int DW  = 64,
  parameter int LAT = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] rd
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] pipe [LAT];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    if (re) pipe[0] <= mem[addr];
  end

  generate
    for (genvar k = 1; k < LAT; k++) begin : g_stage
      always_ff @(posedge clk) pipe[k] <= pipe[k-1];
    end
  endgenerate

  assign rd = pipe[LAT-1];
endmodule

// File: rtl/mop_errlat.sv
`timescale 1ns/1ps
module mop_errlat #(
  parameter int AW = 4,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  logic          clr,
  input  logic [AW-1:0] addr,
  input  logic [SW-1:0] syn,
  output logic          valid,
  output logic          ovf,
  output logic [AW-1:0] eaddr,
  output logic [SW-1:0] esyn
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      ovf   <= 1'b0;
      eaddr <= '0;
      esyn  <= '0;
    end else begin
      if (clr) begin
        valid <= 1'b0;
        ovf   <= 1'b0;
      end
      if (hit) begin
        if (!valid || clr) begin
          valid <= 1'b1;
          eaddr <= addr;
          esyn  <= syn;
        end else begin
          ovf <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mop_seq.sv
`timescale 1ns/1ps
module mop_seq
  import mop_pkg::*;
#(
  parameter int NREQ = 3,
  parameter int AW   = 4,
  parameter int DW   = 64,
  parameter int SW   = 8,
  parameter int LAT  = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NREQ-1:0]      req_valid,
  input  logic [NREQ-1:0]      req_wr,
  input  logic [NREQ*AW-1:0]   req_addr,
  input  logic [NREQ*(DW/8)-1:0] req_mask,
  input  logic [DW-1:0]        wdata,
  input  logic [SW-1:0]        syndrome,
  input  logic                 err_clear,
  output logic [NREQ-1:0]      grant,
  output logic                 ale,
  output logic                 ready,
  output logic                 rd_valid,
  output logic [DW-1:0]        rd_data,
  output logic                 err_valid,
  output logic                 err_ovf,
  output logic [AW-1:0]        err_addr,
  output logic [SW-1:0]        err_syn
);
  localparam int NB = DW / 8;

  logic [NREQ-1:0]  gnt;
  logic             any;
  logic [AW-1:0]    sel_addr;
  logic [NB-1:0]    sel_mask;
  logic             sel_wr;
  op_e              sel_op;

  logic             busy;
  logic [UPC_W-1:0] upc;
  op_e              op;
  logic [AW-1:0]    addr_r;
  logic [AW-1:0]    addr_save;
  logic [NB-1:0]    mask_r;
  logic [DW-1:0]    dreg;
  logic             err_pend;
  uinst_t           ui;
  logic [DW-1:0]    mem_rd;
  logic             mem_we;
  logic             mem_re;
  logic             cap_hit;

  mop_arb #(.NREQ(NREQ)) u_arb (
    .req (req_valid),
    .gnt (gnt),
    .any (any)
  );

  mop_urom #(.LAT(LAT)) u_urom (
    .upc (upc),
    .ui  (ui)
  );

  // lane select by the one-hot grant
  always_comb begin
    sel_addr = '0;
    sel_mask = '0;
    sel_wr   = 1'b0;
    for (int i = 0; i < NREQ; i++) begin
      if (gnt[i]) begin
        sel_addr = req_addr[i*AW +: AW];
        sel_mask = req_mask[i*NB +: NB];
        sel_wr   = req_wr[i];
      end
    end
    if (!sel_wr)         sel_op = OP_READ;
    else if (&sel_mask)  sel_op = OP_FULL;
    else                 sel_op = OP_PART;
  end

  assign mem_we  = busy && ui.mstart && ui.mwe;
  assign mem_re  = busy && ui.mstart && !ui.mwe;
  assign cap_hit = busy && ui.capt && (op != OP_FULL) && (syndrome != '0);

  mop_mem #(.AW(AW), .DW(DW), .LAT(LAT)) u_mem (
    .clk  (clk),
    .we   (mem_we),
    .re   (mem_re),
    .addr (addr_r),
    .wd   (dreg),
    .rd   (mem_rd)
  );

  mop_errlat #(.AW(AW), .SW(SW)) u_errlat (
    .clk   (clk),
    .rst   (rst),
    .hit   (cap_hit),
    .clr   (err_clear),
    .addr  (addr_save),
    .syn   (syndrome),
    .valid (err_valid),
    .ovf   (err_ovf),
    .eaddr (err_addr),
    .esyn  (err_syn)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      upc       <= UPC_READ;
      op        <= OP_READ;
      addr_r    <= '0;
      addr_save <= '0;
      mask_r    <= '0;
      dreg      <= '0;
      err_pend  <= 1'b0;
      grant     <= '0;
      ale       <= 1'b0;
      ready     <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      ale      <= 1'b0;
      ready    <= 1'b0;
      rd_valid <= 1'b0;
      if (!busy) begin
        if (any) begin
          busy      <= 1'b1;
          grant     <= gnt;
          ale       <= 1'b1;
          addr_r    <= sel_addr;
          addr_save <= sel_addr;
          mask_r    <= sel_mask;
          op        <= sel_op;
          err_pend  <= 1'b0;
          unique case (sel_op)
            OP_READ: upc <= UPC_READ;
            OP_FULL: upc <= UPC_FULL;
            default: upc <= UPC_PART;
          endcase
        end
      end else begin
        if (ui.ldw) begin
          dreg <= wdata;
        end else if (ui.capt && op != OP_FULL) begin
          err_pend <= (syndrome != '0);
          for (int b = 0; b < NB; b++) begin
            if (op == OP_READ || !mask_r[b]) dreg[b*8 +: 8] <= mem_rd[b*8 +: 8];
          end
        end
        if (ui.last) begin
          if (err_pend && upc != UPC_EXT) begin
            upc <= UPC_EXT;  // one extension period before release
          end else begin
            busy     <= 1'b0;
            grant    <= '0;
            ready    <= 1'b1;
            rd_valid <= (op == OP_READ);
            if (op == OP_READ) rd_data <= dreg;
          end
        end else begin
          upc <= upc + 5'd1;
        end
      end
    end
  end
endmodule

// File: rtl/mop_seq_chk.sv
`timescale 1ns/1ps
module mop_seq_chk #(
  parameter int NREQ = 3,
  parameter int AW   = 4,
  parameter int SW   = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [NREQ-1:0] grant,
  input logic            ale,
  input logic            ready,
  input logic            rd_valid,
  input logic            err_clear,
  input logic            err_valid,
  input logic            err_ovf,
  input logic [AW-1:0]   err_addr,
  input logic [SW-1:0]   err_syn
);
  p_grant_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  p_ale_grant_r2: assert property (@(posedge clk) disable iff (rst)
    ale |-> $onehot(grant));

  p_ale_single_r2: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);

  p_ale_no_ready_r4: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ready);

  p_ready_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready);

  p_rdv_ready_r11: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ready);

  p_err_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (err_valid && !err_clear) |=> (err_valid && $stable(err_addr) && $stable(err_syn)));

  p_ovf_valid_r9: assert property (@(posedge clk) disable iff (rst)
    err_ovf |-> err_valid);

  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (err_clear && err_ovf) |=> !err_ovf);
endmodule

bind mop_seq mop_seq_chk #(.NREQ(NREQ), .AW(AW), .SW(SW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .grant     (grant),
  .ale       (ale),
  .ready     (ready),
  .rd_valid  (rd_valid),
  .err_clear (err_clear),
  .err_valid (err_valid),
  .err_ovf   (err_ovf),
  .err_addr  (err_addr),
  .err_syn   (err_syn)
);

// File: tb/mop_seq_bench.sv
`timescale 1ns/1ps
module mop_seq_bench;
  localparam int NREQ = 3;
  localparam int AW   = 4;
  localparam int DW   = 64;
  localparam int SW   = 8;
  localparam int NB   = DW / 8;
  localparam int NV   = 13;

  // vector: {lanes[2:0], wr, mask[7:0], addr[3:0], syn[7:0], wdata[63:0]}
  localparam logic [87:0] VEC [NV] = '{
    {3'b001, 1'b1, 8'hFF, 4'd3, 8'h00, 64'h0123_4567_89AB_CDEF},  // full write
    {3'b001, 1'b0, 8'h00, 4'd3, 8'h00, 64'h0},                    // read back
    {3'b010, 1'b1, 8'hFF, 4'd5, 8'h00, 64'hFEDC_BA98_7654_3210},
    {3'b100, 1'b1, 8'h0F, 4'd5, 8'h00, 64'h1111_2222_3333_4444},  // partial
    {3'b010, 1'b0, 8'h00, 4'd5, 8'h00, 64'h0},
    {3'b011, 1'b1, 8'hA5, 4'd3, 8'h00, 64'hAAAA_BBBB_CCCC_DDDD},  // lane 0 wins
    {3'b110, 1'b0, 8'h00, 4'd3, 8'h00, 64'h0},                    // lane 1 wins
    {3'b111, 1'b1, 8'h00, 4'd5, 8'h00, 64'h9999_9999_9999_9999},  // zero mask
    {3'b100, 1'b0, 8'h00, 4'd5, 8'h00, 64'h0},
    {3'b001, 1'b0, 8'h00, 4'd3, 8'h3C, 64'h0},                    // read error
    {3'b010, 1'b1, 8'hF0, 4'd5, 8'h11, 64'h5555_6666_7777_8888},  // overflow
    {3'b001, 1'b1, 8'hFF, 4'd9, 8'h77, 64'h0F0F_0F0F_0F0F_0F0F},  // syn ignored
    {3'b100, 1'b0, 8'h00, 4'd9, 8'h00, 64'h0}
  };

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [NREQ-1:0]      req_valid = '0;
  logic [NREQ-1:0]      req_wr = '0;
  logic [NREQ*AW-1:0]   req_addr = '0;
  logic [NREQ*NB-1:0]   req_mask = '0;
  logic [DW-1:0]        wdata = '0;
  logic [SW-1:0]        syndrome = '0;
  logic                 err_clear = 1'b0;
  logic [NREQ-1:0]      grant;
  logic                 ale, ready, rd_valid, err_valid, err_ovf;
  logic [DW-1:0]        rd_data;
  logic [AW-1:0]        err_addr;
  logic [SW-1:0]        err_syn;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] mdl [16];
  bit            m_ev = 0, m_ov = 0;
  logic [AW-1:0] m_ea = '0;
  logic [SW-1:0] m_es = '0;

  always #2.5 clk = ~clk;

  mop_seq u_mop_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_wr(req_wr),
    .req_addr(req_addr), .req_mask(req_mask), .wdata(wdata),
    .syndrome(syndrome), .err_clear(err_clear), .grant(grant), .ale(ale),
    .ready(ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .err_valid(err_valid), .err_ovf(err_ovf), .err_addr(err_addr),
    .err_syn(err_syn)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_err(input string tag);
    chk(err_valid == m_ev, {tag, " err_valid"}, 64'(err_valid), 64'(m_ev));
    chk(err_ovf == m_ov, {tag, " err_ovf"}, 64'(err_ovf), 64'(m_ov));
    if (m_ev) begin
      chk(err_addr == m_ea, {tag, " err_addr"}, 64'(err_addr), 64'(m_ea));
      chk(err_syn == m_es, {tag, " err_syn"}, 64'(err_syn), 64'(m_es));
    end
  endtask

  task automatic do_op(input logic [2:0] vm, input logic wr, input logic [7:0] mk,
                       input logic [3:0] ad, input logic [7:0] sy, input logic [63:0] wd);
    int    w, n, explat;
    bit    isfull, expext, ign_ok;
    string ltag;
    w = 0;
    for (int i = NREQ - 1; i >= 0; i--) if (vm[i]) w = i;
    @(negedge clk);
    for (int i = 0; i < NREQ; i++) begin
      req_addr[i*AW +: AW] = (i == w) ? ad : ~ad;
      req_wr[i]            = wr;
      req_mask[i*NB +: NB] = mk;
    end
    req_valid = vm;
    wdata     = wd;
    syndrome  = sy;
    n = 0;
    do begin @(negedge clk); n++; end while (!ale && n < 10);
    chk(ale && n == 1, "R2 ale one cycle after request", 64'(n), 64'd1);
    chk(grant == (3'b001 << w), "R2 fixed priority grant", 64'(grant), 64'(3'b001 << w));
    req_valid[w] = 1'b0;   // other lanes keep requesting while busy
    isfull = wr && (mk == 8'hFF);
    expext = !isfull && (sy != 8'h00);
    explat = isfull ? 2 : (expext ? 6 : 5);
    ltag   = isfull ? "R4 latency" : (expext ? "R7 latency" : (!wr ? "R3 latency" : "R5 latency"));
    ign_ok = 1'b1;
    n = 0;
    do begin
      @(negedge clk); n++;
      if (ale) ign_ok = 1'b0;
    end while (!ready && n < 20);
    chk(ign_ok, "R2 requests ignored while busy", 64'(ign_ok), 64'd1);
    chk(ready && n == explat, ltag, 64'(n), 64'(explat));
    chk(rd_valid == !wr, "R11 rd_valid only for reads", 64'(rd_valid), 64'(!wr));
    if (!wr) chk(rd_data == mdl[ad], "R3 read data", rd_data, mdl[ad]);
    req_valid = '0;
    syndrome  = '0;
    if (wr) for (int b = 0; b < NB; b++) if (mk[b]) mdl[ad][b*8 +: 8] = wd[b*8 +: 8];
    if (expext) begin
      if (!m_ev) begin m_ev = 1; m_ea = ad; m_es = sy; end
      else m_ov = 1;
    end
    chk_err("R8/R9 error latch");
    @(negedge clk);
    chk(!ready, "R11 ready single pulse", 64'(ready), 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [87:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!ale && grant == '0 && !ready && !rd_valid, "R1 reset outputs",
        {60'd0, ale, ready, rd_valid, |grant}, 64'd0);
    chk(!err_valid && !err_ovf, "R1 reset error latch", {62'd0, err_valid, err_ovf}, 64'd0);

    // table walk: R3, R4, R5, R6 (entry 7 then read), R7, R8, R9
    for (int k = 0; k < NV; k++) begin
      v = VEC[k];
      do_op(v[87:85], v[84], v[83:76], v[75:72], v[71:64], v[63:0]);
    end

    // R10: clear the latch
    @(negedge clk);
    err_clear = 1'b1;
    @(negedge clk);
    err_clear = 1'b0;
    m_ev = 0; m_ov = 0;
    chk(!err_valid && !err_ovf, "R10 clear", {62'd0, err_valid, err_ovf}, 64'd0);

    // R8: fresh capture after clear, partial write with error
    do_op(3'b100, 1'b1, 8'h3C, 4'd9, 8'h5A, 64'hDEAD_BEEF_CAFE_F00D);
    do_op(3'b001, 1'b0, 8'h00, 4'd9, 8'h00, 64'h0);  // R5 merge readback

    // R1 again: reset clears the latch
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!err_valid && !err_ovf && !ready, "R1 reset after errors",
        {61'd0, err_valid, err_ovf, ready}, 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule